// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single read and write requests from an internal core into timed cycles on an external bus with multiplexed address and data. The low address byte and the data byte share one set of lines. The high address byte has its own lines. Each cycle starts with an address latch strobe, so that an external latch can hold the low address while the shared lines carry data. Active-low read and write strobes follow, together with a space code that selects program memory, data memory or I/O.

The core presents a request and holds it until the master shows ready. It then receives a one-clock done pulse, and read data on a read. Software can write a wait count from 0 to 7. Each unit of the count adds one clock to the strobe phase, so slow devices have time to respond. The count is captured when a request is accepted.

Top module: `muxbus_master`

## Requirements
- R1: After reset, both strobes are high, the latch strobe is low, the shared lines are not driven (`bus_ad_oe`=0), the space code is 0, done is low, ready is high and the wait count is 0.
- R2: `req_ready` is high only while the master is idle. A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. A request raised while busy does not disturb the current cycle and starts only after the master returns to idle.
- R3: The first clock of a cycle has `bus_ale`=1 and the low address byte driven on the shared lines. `bus_ale` is high for exactly that one clock.
- R4: The second clock has `bus_ale`=0 and the low address still driven, with both strobes high.
- R5: In a read, the strobe phase lasts 2+W clocks with `bus_rd_n`=0 and `bus_ad_oe`=0 throughout.
- R6: Read data is sampled from `bus_ad_i` on the last strobe clock only, and appears on `rsp_rdata` with the done pulse.
- R7: In a write, the write byte is driven for all 2+W strobe clocks. `bus_wr_n` is low from the second strobe clock to the last, giving one clock of data setup.
- R8: One end clock follows the strobe phase. In it, `rsp_done`=1 for exactly that clock, the shared lines are released, the high address lines and space code read 0, and both strobes are high.
- R9: The wait count W (0..7) loads on a clock where `cfg_we`=1 and is captured at request acceptance. A write to it during a cycle affects only later cycles.
- R10: The high address byte and the space code (1 program, 2 data, 3 I/O) are driven unchanged from the first clock through the last strobe clock. Addresses 0x0000 through 0xFFFF all reach the pins intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the wait count |
| cfg_wait | input | 3 | New wait count |
| req_valid | input | 1 | Core request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | Space code 1 program, 2 data, 3 I/O |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Master idle, request will be taken |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | 8 | Sampled read byte |
| bus_ad_o | output | 8 | Shared address/data lines, output value |
| bus_ad_oe | output | 1 | Drive enable for shared lines |
| bus_ad_i | input | 8 | Shared lines, input value |
| bus_addr_hi | output | 8 | High address byte |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_space | output | 2 | Space code, 0 when idle |

## Verification
The bench presents a wrong byte on the shared lines on every strobe clock except the last. A design that samples early, or one clock late, therefore returns the inverted byte. It raises stray requests in the middle of cycles and chains a held request straight after a cycle. A master that accepted while busy would pulse the latch strobe out of place, and one that dropped the held request would never start it. The bench also writes the wait count in the middle of a cycle, where a design that did not capture W at acceptance would stretch or shorten the running strobe phase. Addresses 0x0000 and 0xFFFF, every wait value and every space code are covered, so a swapped or truncated address byte shows at once.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_HOLD   = 3'd2,
    PH_STROBE = 3'd3,
    PH_END    = 3'd4
  } phase_e;

  localparam logic [1:0] SPC_NONE = 2'd0;

  // strobe phase length in clocks for a given wait count
  function automatic int unsigned strobe_clocks(input int unsigned w);
    return 2 + w;
  endfunction

endpackage

// File: rtl/muxbus_waitcfg.sv
module muxbus_waitcfg #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic [WAIT_W-1:0] wait_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wait_q <= '0;
    else if (cfg_we) wait_q <= cfg_wait;
  end

  // R9: value follows a write one clock later
  p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> wait_q == $past(cfg_wait));

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WAIT_W-1:0] wait_cfg,
  output phase_e            phase,
  output logic              req_ready,
  output logic              accept,
  output logic              strobe_first,
  output logic              strobe_last
);

  localparam int CNT_W = WAIT_W + 1;

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WAIT_W-1:0] w_lat_q;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx     = CNT_W'(strobe_clocks(32'(w_lat_q)) - 1);
  assign phase        = phase_q;
  assign req_ready    = (phase_q == PH_IDLE);
  assign accept       = req_ready && req_valid;
  assign strobe_first = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign strobe_last  = (phase_q == PH_STROBE) && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      w_lat_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (req_valid) begin
          phase_q <= PH_ALE;
          w_lat_q <= wait_cfg;
        end
        PH_ALE:  phase_q <= PH_HOLD;
        PH_HOLD: begin
          phase_q <= PH_STROBE;
          cnt_q   <= '0;
        end
        PH_STROBE: begin
          if (strobe_last) phase_q <= PH_END;
          else             cnt_q   <= cnt_q + 1'b1;
        end
        PH_END:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2: a cycle starts only from idle with a pending request
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ALE) |-> ($past(phase_q) == PH_IDLE) && $past(req_valid));

  // R4: address hold clock always follows the latch clock
  p_hold_after_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ALE) |=> (phase_q == PH_HOLD));

  // R8: end clock follows the last strobe clock, then idle
  p_end_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_last |=> (phase_q == PH_END) ##1 (phase_q == PH_IDLE));

  // R9: counter stays within the latched window
  p_cnt_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE) |-> (cnt_q <= last_idx));

endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_e                   phase,
  input  logic                     accept,
  input  logic                     strobe_first,
  input  logic                     strobe_last,
  input  logic                     req_write,
  input  logic [1:0]               req_space,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic [1:0]               bus_space
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic [1:0]        space_q;

  // named phase events
  logic in_addr, in_strobe, in_cycle, rd_sample;
  assign in_addr   = (phase == PH_ALE) || (phase == PH_HOLD);
  assign in_strobe = (phase == PH_STROBE);
  assign in_cycle  = in_addr || in_strobe;
  assign rd_sample = strobe_last && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      space_q   <= SPC_NONE;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        space_q <= req_space;
      end
      if (rd_sample) rsp_rdata <= bus_ad_i;
    end
  end

  always_comb begin
    bus_ale     = (phase == PH_ALE);
    bus_ad_oe   = in_addr || (in_strobe && wr_q);
    if (in_addr)                 bus_ad_o = addr_q[DATA_W-1:0];
    else if (in_strobe && wr_q)  bus_ad_o = wdata_q;
    else                         bus_ad_o = '0;
    bus_addr_hi = in_cycle ? addr_q[ADDR_W-1:DATA_W] : '0;
    bus_space   = in_cycle ? space_q : SPC_NONE;
    bus_rd_n    = !(in_strobe && !wr_q);
    bus_wr_n    = !(in_strobe && wr_q && !strobe_first);
    rsp_done    = (phase == PH_END);
  end

  // R3: latch strobe is a single clock, followed by held address
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale && bus_ad_oe && $stable(bus_ad_o));

  // R5: never drive the shared lines while reading
  p_rd_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);

  // R5: strobes never both active
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R7: write data was already on the lines before the strobe falls
  p_wr_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_ad_oe) && bus_ad_oe && $stable(bus_ad_o));

  // R8: done is one clock and everything is released then
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !bus_ad_oe && bus_rd_n && bus_wr_n && (bus_space == SPC_NONE)
                 ##1 !rsp_done);

  // R10: high address and space stay fixed through the strobe phase
  p_hi_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && $past(in_cycle)) |-> $stable(bus_addr_hi) && $stable(bus_space));

endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [WAIT_W-1:0]        cfg_wait,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [1:0]               req_space,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic [1:0]               bus_space
);

  logic [WAIT_W-1:0] wait_q;
  phase_e            phase;
  logic              accept, strobe_first, strobe_last;

  muxbus_waitcfg #(.WAIT_W(WAIT_W)) u_waitcfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wait (cfg_wait),
    .wait_q   (wait_q)
  );

  muxbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .wait_cfg     (wait_q),
    .phase        (phase),
    .req_ready    (req_ready),
    .accept       (accept),
    .strobe_first (strobe_first),
    .strobe_last  (strobe_last)
  );

  muxbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .accept       (accept),
    .strobe_first (strobe_first),
    .strobe_last  (strobe_last),
    .req_write    (req_write),
    .req_space    (req_space),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .bus_ad_i     (bus_ad_i),
    .rsp_done     (rsp_done),
    .rsp_rdata    (rsp_rdata),
    .bus_ad_o     (bus_ad_o),
    .bus_ad_oe    (bus_ad_oe),
    .bus_addr_hi  (bus_addr_hi),
    .bus_ale      (bus_ale),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_space    (bus_space)
  );

  // R2: ready never seen in the clock of a latch strobe
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !req_ready);

endmodule

// File: tb/muxbus_master_tb.sv
`timescale 1ns/1ps
module muxbus_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wait = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_space = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  bus_ad_i = '0;
  logic        req_ready, rsp_done, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n;
  logic [7:0]  rsp_rdata, bus_ad_o, bus_addr_hi;
  logic [1:0]  bus_space;

  int vec = 0;
  int bad = 0;
  int cur_w = 0;
  bit finished = 1'b0;
  bit          nx_wr;
  logic [1:0]  nx_sp;
  logic [15:0] nx_a;
  logic [7:0]  nx_d;

  always #4 clk = ~clk;

  muxbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_write(req_write), .req_space(req_space),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_addr_hi(bus_addr_hi),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_space(bus_space)
  );

  function automatic logic [7:0] mem_of(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_wait(input int v);
    cfg_we = 1'b1; cfg_wait = 3'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_w = v;
  endtask

  // one full bus cycle; entered and left at a negedge while idle
  task automatic run_cycle(input bit wr, input logic [1:0] sp, input logic [15:0] a,
                           input logic [7:0] d, input bit chain, input bit mid_cfg,
                           input int mid_w);
    int w;
    bit strb, oe_e;
    w = cur_w;
    req_write = wr; req_space = sp; req_addr = a; req_wdata = d; req_valid = 1'b1;
    chk("R2 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= 4 + w; c++) begin
      strb = (c >= 2) && (c <= 3 + w);
      oe_e = (c < 2) || (strb && wr);
      bus_ad_i = (c == 3 + w) ? mem_of(a) : ~mem_of(a);
      chk("R3 ale", bus_ale, c == 0);
      chk("R5 R7 oe", bus_ad_oe, oe_e);
      if (c < 2)            chk("R4 low address", bus_ad_o, a[7:0]);
      else if (strb && wr)  chk("R7 write data", bus_ad_o, d);
      chk("R10 high address", bus_addr_hi, (c <= 3 + w) ? a[15:8] : 8'h00);
      chk("R10 space", bus_space, (c <= 3 + w) ? sp : 2'd0);
      chk("R5 rd_n", bus_rd_n, !(strb && !wr));
      chk("R7 wr_n", bus_wr_n, !(strb && wr && c >= 3));
      chk("R8 done", rsp_done, c == 4 + w);
      chk("R2 busy not ready", req_ready, 0);
      if (c == 4 + w && !wr) chk("R6 read data", rsp_rdata, mem_of(a));
      if (!chain && c == 1) begin req_valid = 1'b1; req_addr = 16'($urandom); end
      if (!chain && c == 4 + w) req_valid = 1'b0;
      if (chain && c == 2) begin
        req_write = nx_wr; req_space = nx_sp; req_addr = nx_a; req_wdata = nx_d;
        req_valid = 1'b1;
      end
      if (mid_cfg && c == 1) begin cfg_we = 1'b1; cfg_wait = 3'(mid_w); end
      if (mid_cfg && c == 2) cfg_we = 1'b0;
      @(negedge clk);
    end
    if (mid_cfg) cur_w = mid_w;
    chk("R8 ready after end", req_ready, 1);
    chk("R8 done cleared", rsp_done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ale", bus_ale, 0);
    chk("R1 rd_n", bus_rd_n, 1);
    chk("R1 wr_n", bus_wr_n, 1);
    chk("R1 oe", bus_ad_oe, 0);
    chk("R1 space", bus_space, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 ready", req_ready, 1);
    // R1 / R9: wait count resets to zero
    run_cycle(1'b0, 2'd1, 16'h0000, 8'h00, 1'b0, 1'b0, 0);
    run_cycle(1'b1, 2'd3, 16'hFFFF, 8'hA5, 1'b0, 1'b0, 0);
    set_wait(7);
    run_cycle(1'b0, 2'd2, 16'h1234, 8'h00, 1'b0, 1'b0, 0);
    // R9: mid-cycle wait write affects only the next cycle
    run_cycle(1'b1, 2'd2, 16'h8001, 8'h3C, 1'b0, 1'b1, 2);
    run_cycle(1'b0, 2'd3, 16'h00FF, 8'h00, 1'b0, 1'b0, 0);
    // R2: held request chained behind a busy cycle
    nx_wr = 1'b1; nx_sp = 2'd1; nx_a = 16'hFF00; nx_d = 8'h96;
    run_cycle(1'b0, 2'd2, 16'h7E81, 8'h00, 1'b1, 1'b0, 0);
    run_cycle(nx_wr, nx_sp, nx_a, nx_d, 1'b0, 1'b0, 0);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 4) == 0) set_wait(int'($urandom % 8));
      run_cycle(1'($urandom), 2'(1 + ($urandom % 3)), 16'($urandom), 8'($urandom),
                1'b0, (($urandom % 8) == 0), int'($urandom % 8));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule